// File: doc/BRIEF.md
# Circular Descriptor Ring Fetch Engine

This block runs one DMA pipe from a circular ring of 8-byte descriptors kept in memory. Software fills ring entries, then writes the byte offset just past the last new entry into the tail register. The engine compares its own offset with that tail. While they differ, and the pipe is enabled and not halted, it reads the descriptor at `base + offset` over a single-beat read port. It passes the descriptor's buffer address, length and flags to a transfer backend and waits for the backend's done pulse. Then it steps the offset by 8, wrapping to 0 at the ring size.

A flag bit in a descriptor asks for a completion pulse. Another flag bit asks for an end-of-transfer pulse. A third pulse marks the moment the ring drains. The current offset is always visible as status. A sticky error bit records a rejected tail write. A pipe reset register, written high and then low, puts every pipe setting and the offset back to their defaults.

The ring holds one entry fewer than its size in descriptors. When the offset equals the tail, the ring is always empty, never full.

Top module: `ring_walker`

## Requirements
- R1: After reset: `cur_ofs` is 0, `ofs_err` is 0, the pipe is disabled, base is 0, ring size is 32768 bytes, and neither `rd_req` nor `xfer_valid` is asserted.
- R2: A descriptor is read as one 64-bit word. Bits [31:0] are the buffer address, [47:32] the byte length and [63:48] the flags. It is read from address `base + cur_ofs`, and the three fields appear unchanged on `xfer_addr`, `xfer_len` and `xfer_flags`.
- R3: Only one descriptor is in flight at a time. No read is requested while `xfer_valid` is high. `cur_ofs` changes only when the backend completes a descriptor, and then it grows by 8.
- R4: A valid write to the tail register (address 5) sets the tail. The engine works through descriptors until `cur_ofs` equals the tail, going from offset `size-8` back to 0.
- R5: A tail write whose low 3 bits are not zero, or whose value is not below the ring size, is ignored and sets the sticky `ofs_err`.
- R6: Control register (address 0): bit 1 enables the pipe and bit 3 sets the direction (1 = peripheral to memory), which is driven on `xfer_dir`. With enable at 0, no read is requested.
- R7: Halt register (address 2), bit 0. While it is 1, no new descriptor fetch starts. Clearing it resumes from the same offset.
- R8: Pipe reset register (address 1), bit 0. While it is 1, all pipe registers, the offset, the error bit and the sequencer return to their defaults. Once it is written back to 0, the pipe stays disabled until it is enabled again.
- R9: `ev_int` pulses for one cycle, the cycle after a descriptor with flag bit 15 completes. `ev_eot` does the same for flag bit 14. Bit 13 (end of block) is only passed through.
- R10: `ev_empty` pulses once, the cycle after the completion that brings `cur_ofs` equal to the tail.
- R11: Base register (address 3) and ring-size register (address 4) drop the low 3 bits of the written value, so both stay 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| rd_req | output | 1 | Descriptor read request, one cycle |
| rd_addr | output | 32 | Descriptor read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response descriptor word |
| xfer_valid | output | 1 | Descriptor presented to backend |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 16 | Buffer length in bytes |
| xfer_flags | output | 16 | Descriptor flags |
| xfer_dir | output | 1 | Direction, 1 = peripheral to memory |
| xfer_done | input | 1 | Backend completion pulse |
| cur_ofs | output | 16 | Current ring byte offset |
| ofs_err | output | 1 | Sticky rejected-tail flag |
| ev_int | output | 1 | Completion event pulse |
| ev_eot | output | 1 | End-of-transfer event pulse |
| ev_empty | output | 1 | Ring drained pulse |

## Verification
A register write takes effect at the edge that samples it. When the engine is idle, `rd_req` rises one cycle after a tail write that creates work. The descriptor fields reach the backend in the cycle after `rd_valid`. The offset step and the event pulses land one edge after `xfer_done`. The bench drives and samples only on falling edges. After each stimulus it waits a fixed margin of several descriptor periods before it compares counters, logs and `cur_ofs`, so every result has settled before it is read. The event and overlap counters are kept by a falling-edge monitor, so a one-cycle pulse is never missed.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int DESC_BYTES = 8;
  localparam int DESC_SHIFT = 3;
  localparam int FLG_INT    = 15;
  localparam int FLG_EOT    = 14;
  localparam int CTL_EN     = 1;
  localparam int CTL_DIR    = 3;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_RST  = 3'd1,
    RA_HALT = 3'd2,
    RA_BASE = 3'd3,
    RA_SIZE = 3'd4,
    RA_TAIL = 3'd5
  } reg_addr_t;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_XFER} seq_state_t;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
    logic [31:0] addr;
  } desc_t;
endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import ring_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFS_W    = 16,
  parameter int SIZE_DEF = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       waddr,
  input  logic [AW-1:0]    wdata,
  output logic             clr,
  output logic             en,
  output logic             dir,
  output logic             halt,
  output logic [AW-1:0]    base,
  output logic [OFS_W-1:0] size,
  output logic [OFS_W-1:0] tail,
  output logic             err
);
  localparam logic [OFS_W-1:0] SIZE_RST = OFS_W'(SIZE_DEF);

  logic             prst_q, prst_d, en_q, en_d, dir_q, dir_d, halt_q, halt_d, err_q, err_d;
  logic [AW-1:0]    base_q, base_d;
  logic [OFS_W-1:0] size_q, size_d, tail_q, tail_d;
  logic             hit_rst, tail_ok;

  assign hit_rst = we && (waddr == RA_RST);
  assign tail_ok = (wdata[DESC_SHIFT-1:0] == '0) && (wdata[AW-1:OFS_W] == '0) &&
                   (wdata[OFS_W-1:0] < size_q);
  assign clr     = prst_q | (hit_rst & wdata[0]);

  always_comb begin
    prst_d = hit_rst ? wdata[0] : prst_q;
    en_d   = en_q;
    dir_d  = dir_q;
    halt_d = halt_q;
    base_d = base_q;
    size_d = size_q;
    tail_d = tail_q;
    err_d  = err_q;
    if (clr) begin
      en_d   = 1'b0;
      dir_d  = 1'b0;
      halt_d = 1'b0;
      base_d = '0;
      size_d = SIZE_RST;
      tail_d = '0;
      err_d  = 1'b0;
    end else if (we) begin
      case (reg_addr_t'(waddr))
        RA_CTRL: begin
          en_d  = wdata[CTL_EN];
          dir_d = wdata[CTL_DIR];
        end
        RA_HALT: halt_d = wdata[0];
        RA_BASE: base_d = {wdata[AW-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        RA_SIZE: size_d = {wdata[OFS_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        RA_TAIL: begin
          if (tail_ok) tail_d = wdata[OFS_W-1:0];
          else         err_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prst_q <= 1'b0;
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      halt_q <= 1'b0;
      base_q <= '0;
      size_q <= SIZE_RST;
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      prst_q <= prst_d;
      en_q   <= en_d;
      dir_q  <= dir_d;
      halt_q <= halt_d;
      base_q <= base_d;
      size_q <= size_d;
      tail_q <= tail_d;
      err_q  <= err_d;
    end
  end

  assign en   = en_q;
  assign dir  = dir_q;
  assign halt = halt_q;
  assign base = base_q;
  assign size = size_q;
  assign tail = tail_q;
  assign err  = err_q;

  // R5
  bad_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr == RA_TAIL) && !tail_ok && !clr) |=> (err_q && $stable(tail_q)));
endmodule

// File: rtl/ring_ofs.sv
module ring_ofs
  import ring_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [OFS_W-1:0] size,
  input  logic [OFS_W-1:0] tail,
  output logic [OFS_W-1:0] cur,
  output logic             pending,
  output logic             ev_empty
);
  logic [OFS_W-1:0] cur_q, cur_d;
  logic [OFS_W:0]   step;
  logic             emp_q, emp_d;

  assign step = {1'b0, cur_q} + (OFS_W+1)'(DESC_BYTES);

  always_comb begin
    cur_d = cur_q;
    emp_d = 1'b0;
    if (clr) begin
      cur_d = '0;
    end else if (adv) begin
      cur_d = (step >= {1'b0, size}) ? '0 : step[OFS_W-1:0];
      emp_d = (cur_d == tail);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      emp_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      emp_q <= emp_d;
    end
  end

  assign cur      = cur_q;
  assign pending  = (cur_q != tail);
  assign ev_empty = emp_q;

  // R10
  empty_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |=> !ev_empty);
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> ((cur_q == $past(cur_q) + OFS_W'(DESC_BYTES)) || (cur_q == '0)));
endmodule

// File: rtl/ring_seq.sv
module ring_seq
  import ring_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  logic [AW-1:0]    base,
  input  logic [OFS_W-1:0] cur,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [63:0]      rd_data,
  output logic             xfer_valid,
  output desc_t            desc,
  input  logic             xfer_done,
  output logic             adv,
  output logic             ev_int,
  output logic             ev_eot
);
  seq_state_t state_q, state_d;
  desc_t      desc_q, desc_d;
  logic       int_q, int_d, eot_q, eot_d;

  assign adv = (state_q == S_XFER) && xfer_done && !clr;

  always_comb begin
    state_d = state_q;
    desc_d  = desc_q;
    int_d   = adv && desc_q.flags[FLG_INT];
    eot_d   = adv && desc_q.flags[FLG_EOT];
    if (clr) begin
      state_d = S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (go) state_d = S_REQ;
        S_REQ:  state_d = S_WAIT;
        S_WAIT: if (rd_valid) begin
          desc_d  = desc_t'(rd_data);
          state_d = S_XFER;
        end
        S_XFER: if (xfer_done) state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      int_q   <= 1'b0;
      eot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      int_q   <= int_d;
      eot_q   <= eot_d;
    end
  end

  assign rd_req     = (state_q == S_REQ);
  assign rd_addr    = base + AW'(cur);
  assign xfer_valid = (state_q == S_XFER);
  assign desc       = desc_q;
  assign ev_int     = int_q;
  assign ev_eot     = eot_q;
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import ring_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFS_W    = 16,
  parameter int SIZE_DEF = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [AW-1:0]    cfg_wdata,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [63:0]      rd_data,
  output logic             xfer_valid,
  output logic [31:0]      xfer_addr,
  output logic [15:0]      xfer_len,
  output logic [15:0]      xfer_flags,
  output logic             xfer_dir,
  input  logic             xfer_done,
  output logic [OFS_W-1:0] cur_ofs,
  output logic             ofs_err,
  output logic             ev_int,
  output logic             ev_eot,
  output logic             ev_empty
);
  logic             clr, en, dir, halt, pending, go, adv;
  logic [AW-1:0]    base;
  logic [OFS_W-1:0] size, tail;
  desc_t            desc;

  ring_cfg #(.AW(AW), .OFS_W(OFS_W), .SIZE_DEF(SIZE_DEF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .clr(clr), .en(en), .dir(dir), .halt(halt), .base(base), .size(size),
    .tail(tail), .err(ofs_err)
  );

  ring_ofs #(.OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .size(size), .tail(tail),
    .cur(cur_ofs), .pending(pending), .ev_empty(ev_empty)
  );

  assign go = en && !halt && pending;

  ring_seq #(.AW(AW), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(go), .base(base), .cur(cur_ofs),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_valid(xfer_valid), .desc(desc), .xfer_done(xfer_done), .adv(adv),
    .ev_int(ev_int), .ev_eot(ev_eot)
  );

  assign xfer_addr  = desc.addr;
  assign xfer_len   = desc.len;
  assign xfer_flags = desc.flags;
  assign xfer_dir   = dir;

  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !rd_req);
  // R7
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(halt) |-> !rd_req);
  // R3
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !rd_req);
  // R3
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(adv) && !$past(clr)) |-> $stable(cur_ofs));
  // R9
  int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int |-> $past(xfer_valid && xfer_done));
  // R8
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (!rd_req && !xfer_valid && !en));
endmodule

// File: tb/sim_ring_walker.sv
`timescale 1ns/1ps
module sim_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_req, rd_valid = 1'b0;
  logic [31:0] rd_addr;
  logic [63:0] rd_data = '0;
  logic        xfer_valid, xfer_dir, xfer_done = 1'b0;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len, xfer_flags, cur_ofs;
  logic        ofs_err, ev_int, ev_eot, ev_empty;

  int checks = 0, errors = 0;
  int nf = 0, nx = 0, n_int = 0, n_eot = 0, n_emp = 0, n_ovl = 0;
  logic [31:0] fa [0:31];
  logic [31:0] la [0:31];
  logic [15:0] ll [0:31];
  logic [15:0] lf [0:31];
  logic        ld [0:31];
  logic [63:0] mem [0:7];
  bit          ended = 1'b0;

  always #5 clk = ~clk;

  ring_walker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_flags(xfer_flags), .xfer_dir(xfer_dir), .xfer_done(xfer_done),
    .cur_ofs(cur_ofs), .ofs_err(ofs_err), .ev_int(ev_int), .ev_eot(ev_eot),
    .ev_empty(ev_empty)
  );

  // memory read model: answers two cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [2:0] idx;
        idx = rd_addr[5:3];
        if (nf < 32) fa[nf] = rd_addr;
        nf++;
        repeat (2) @(negedge clk);
        rd_data  = mem[idx];
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // transfer backend model: completes one cycle after a descriptor shows up
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_valid && !xfer_done) begin
        if (nx < 32) begin
          la[nx] = xfer_addr; ll[nx] = xfer_len; lf[nx] = xfer_flags; ld[nx] = xfer_dir;
        end
        nx++;
        xfer_done = 1'b1;
      end else begin
        xfer_done = 1'b0;
      end
    end
  end

  // event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (ev_int)   n_int++;
      if (ev_eot)   n_eot++;
      if (ev_empty) n_emp++;
      if (rd_req && xfer_valid) n_ovl++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_x(input int k, input int idx, input string req);
    chk(la[k] == mem[idx][31:0],  req, 64'(la[k]), 64'(mem[idx][31:0]));
    chk(ll[k] == mem[idx][47:32], req, 64'(ll[k]), 64'(mem[idx][47:32]));
    chk(lf[k] == mem[idx][63:48], req, 64'(lf[k]), 64'(mem[idx][63:48]));
  endtask

  task automatic finish_sim;
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset;
    chk(cur_ofs == 0, "R1 offset", 64'(cur_ofs), 0);
    chk(ofs_err == 0, "R1 error", 64'(ofs_err), 0);
    chk(!rd_req && !xfer_valid, "R1 idle", 64'({rd_req, xfer_valid}), 0);
  endtask

  task automatic t_disabled;
    int x0 = nx;
    wr(3'd5, 32'd16);
    idle(30);
    chk(nx == x0, "R6 disabled no work", 64'(nx - x0), 0);
    chk(cur_ofs == 0, "R6 disabled offset", 64'(cur_ofs), 0);
    chk(ofs_err == 0, "R1 default size accepts 16", 64'(ofs_err), 0);
  endtask

  task automatic t_basic;
    int f0 = nf, x0 = nx, i0 = n_int, e0 = n_eot, m0 = n_emp;
    wr(3'd3, 32'h0000_1005);
    wr(3'd0, 32'h0000_000A);
    idle(60);
    chk(nx - x0 == 2, "R4 two descriptors", 64'(nx - x0), 2);
    chk(fa[f0] == 32'h1000, "R11 R2 fetch addr 0", 64'(fa[f0]), 64'h1000);
    chk(fa[f0+1] == 32'h1008, "R2 fetch addr 1", 64'(fa[f0+1]), 64'h1008);
    chk_x(x0, 0, "R2 desc 0 fields");
    chk_x(x0 + 1, 1, "R2 desc 1 fields");
    chk(ld[x0] == 1'b1, "R6 direction", 64'(ld[x0]), 1);
    chk(cur_ofs == 16, "R3 offset step", 64'(cur_ofs), 16);
    chk(n_int - i0 == 1, "R9 int pulses", 64'(n_int - i0), 1);
    chk(n_eot - e0 == 1, "R9 eot pulses", 64'(n_eot - e0), 1);
    chk(n_emp - m0 == 1, "R10 empty pulses", 64'(n_emp - m0), 1);
    chk(n_ovl == 0, "R3 no overlap", 64'(n_ovl), 0);
  endtask

  task automatic t_wrap;
    int f0 = nf, x0 = nx, i0 = n_int, m0 = n_emp;
    wr(3'd4, 32'h0000_0047);
    wr(3'd5, 32'd8);
    idle(120);
    chk(nx - x0 == 7, "R4 wrap count", 64'(nx - x0), 7);
    for (int k = 0; k < 6; k++)
      chk(fa[f0+k] == 32'h1000 + 32'(16 + 8*k), "R4 wrap order",
          64'(fa[f0+k]), 64'(32'h1000 + 32'(16 + 8*k)));
    chk(fa[f0+6] == 32'h1000, "R11 R4 wrap to 0", 64'(fa[f0+6]), 64'h1000);
    chk_x(x0 + 6, 0, "R2 wrapped desc");
    chk(cur_ofs == 8, "R4 wrap offset", 64'(cur_ofs), 8);
    chk(n_int - i0 == 1, "R9 int after wrap", 64'(n_int - i0), 1);
    chk(n_emp - m0 == 1, "R10 empty once", 64'(n_emp - m0), 1);
  endtask

  task automatic t_bad_tail;
    int x0 = nx;
    wr(3'd5, 32'd12);
    chk(ofs_err == 1, "R5 misaligned sets err", 64'(ofs_err), 1);
    wr(3'd5, 32'd64);
    idle(30);
    chk(nx == x0, "R5 ignored tail no work", 64'(nx - x0), 0);
    chk(cur_ofs == 8, "R5 offset kept", 64'(cur_ofs), 8);
    chk(ofs_err == 1, "R5 sticky err", 64'(ofs_err), 1);
  endtask

  task automatic t_halt;
    int f0 = nf, x0 = nx, e0 = n_eot;
    wr(3'd2, 32'd1);
    wr(3'd5, 32'd24);
    idle(30);
    chk(nx == x0, "R7 halted no work", 64'(nx - x0), 0);
    chk(cur_ofs == 8, "R7 halted offset", 64'(cur_ofs), 8);
    wr(3'd2, 32'd0);
    idle(50);
    chk(nx - x0 == 2, "R7 resume count", 64'(nx - x0), 2);
    chk(fa[f0] == 32'h1008, "R7 resume position", 64'(fa[f0]), 64'h1008);
    chk(cur_ofs == 24, "R7 resume offset", 64'(cur_ofs), 24);
    chk(n_eot - e0 == 1, "R9 eot on resume", 64'(n_eot - e0), 1);
  endtask

  task automatic t_pipe_reset;
    int f0, x0;
    wr(3'd1, 32'd1);
    wr(3'd1, 32'd0);
    chk(cur_ofs == 0, "R8 offset cleared", 64'(cur_ofs), 0);
    chk(ofs_err == 0, "R8 err cleared", 64'(ofs_err), 0);
    wr(3'd5, 32'h0000_7FF8);
    chk(ofs_err == 0, "R8 R1 size back to 32768", 64'(ofs_err), 0);
    wr(3'd5, 32'h0000_8000);
    chk(ofs_err == 1, "R5 tail equal size", 64'(ofs_err), 1);
    wr(3'd5, 32'd16);
    x0 = nx;
    idle(30);
    chk(nx == x0, "R8 pipe disabled after reset", 64'(nx - x0), 0);
    f0 = nf;
    wr(3'd0, 32'h0000_0002);
    idle(60);
    chk(nx - x0 == 2, "R8 work after enable", 64'(nx - x0), 2);
    chk(fa[f0] == 32'h0, "R8 base cleared", 64'(fa[f0]), 0);
    chk(ld[x0] == 1'b0, "R6 direction 0", 64'(ld[x0]), 0);
    chk(cur_ofs == 16, "R8 final offset", 64'(cur_ofs), 16);
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      mem[i] = {16'h0000, 16'h0040 + 16'(i), 32'hA000_0000 + 32'(i << 8)};
    mem[0][63:48] = 16'h8000;
    mem[1][63:48] = 16'h4000;
    mem[2][63:48] = 16'h2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_disabled;
    t_basic;
    t_wrap;
    t_bad_tail;
    t_halt;
    t_pipe_reset;
    idle(5);
    finish_sim;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_sim;
  end
endmodule